// File: doc/BRIEF.md
# Outstanding Memory Operation Fence Unit

This block sits beside a processor's instruction issue stage. It keeps count of memory requests that have been sent into a pipelined, packet-switched path to shared memory and whose completion receipt has not yet returned. Loads and stores leave back to back and never wait for their own receipts. Receipts carry no tag. They may come back in any order, so the block only tracks how many are still outstanding.

Ordering exists only where software asks for it. When the issue stage presents a sync instruction, the block holds that instruction and everything behind it until the outstanding count is zero. The sync then retires. A producer puts a sync between writing a block of data and setting the flag that announces the data, so the flag store cannot reach memory ahead of the data. The count has a fixed ceiling. A memory instruction that would exceed it is held. A receipt that arrives with nothing outstanding is reported and does not wrap the count.

Top module: `fence_unit`

## Requirements
- R1: A synchronous active-high `rst` clears the outstanding count to 0 and drives `stall_o` and `rcpt_err_o` low.
- R2: A valid memory instruction (`instr_valid_i`=1, `instr_mem_i`=1, `instr_sync_i`=0) is accepted when the count is below `MAX_OUT`. In that case `mem_issue_o` is high in the same cycle, `stall_o` is low, and the count rises by one at the next edge. Consecutive memory instructions issue on consecutive cycles.
- R3: A receipt (`rcpt_i`=1) while the count is nonzero lowers the count by one at the next edge. Receipts are untagged, so the order in which they return does not matter.
- R4: A request accepted in the same cycle as a receipt counted against a nonzero count leaves the count unchanged.
- R5: A valid sync while the count is nonzero drives `stall_o` high and `sync_retire_o` low in the same cycle, and this repeats every cycle the count stays nonzero.
- R6: A valid sync while the count is zero drives `sync_retire_o` high and `stall_o` low in the same cycle. The sync therefore retires in the first cycle in which the final receipt has been counted.
- R7: While the count equals `MAX_OUT`, a valid memory instruction drives `stall_o` high and `mem_issue_o` low, and the count does not rise. A valid instruction that is neither memory nor sync is not stalled, and an input with `instr_valid_i`=0 never stalls.
- R8: A receipt arriving while the count is zero raises `rcpt_err_o` for exactly one cycle, the cycle after the receipt. That receipt does not decrement the count. A request accepted in the same cycle still counts, so the count becomes 1.
- R9: An instruction with both `instr_sync_i` and `instr_mem_i` set is treated as a sync. It never asserts `mem_issue_o` and never increments the count.
- R10: `pend_cnt_o` always shows the registered outstanding count, which never exceeds `MAX_OUT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid_i | input | 1 | Issue stage presents an instruction |
| instr_sync_i | input | 1 | Presented instruction is a sync |
| instr_mem_i | input | 1 | Presented instruction is a load or store |
| rcpt_i | input | 1 | One completion receipt returned from memory |
| stall_o | output | 1 | Hold the presented instruction and all later ones |
| mem_issue_o | output | 1 | Memory request sent this cycle |
| sync_retire_o | output | 1 | Sync retires this cycle |
| rcpt_err_o | output | 1 | Previous cycle had a receipt with nothing outstanding |
| pend_cnt_o | output | $clog2(MAX_OUT+1) | Outstanding request count |

## Verification
Two events can fall in the same cycle: a request being accepted and a receipt being counted. The bench provokes this by driving `instr_mem_i` and `rcpt_i` together at three counts.
- At a nonzero count, the count must hold.
- At zero, the count must become 1 and an error must follow.
- At the ceiling, the request is refused, so the count must fall by one.

It also overlaps a waiting sync with a stream of receipts. The bench checks that the stall releases in exactly the cycle the count reads zero.

// File: rtl/fence_pkg.sv
package fence_pkg;

    // Class of the instruction presented by the issue stage
    typedef enum logic [1:0] {
        KIND_IDLE  = 2'd0,
        KIND_OTHER = 2'd1,
        KIND_MEM   = 2'd2,
        KIND_SYNC  = 2'd3
    } ikind_e;

    // Sync takes precedence over the memory flag (R9)
    function automatic ikind_e classify(input logic valid, input logic sync, input logic mem);
        if (!valid)    return KIND_IDLE;
        else if (sync) return KIND_SYNC;
        else if (mem)  return KIND_MEM;
        else           return KIND_OTHER;
    endfunction

endpackage

// File: rtl/fence_classify.sv
module fence_classify
    import fence_pkg::*;
(
    input  logic   valid_i,
    input  logic   sync_i,
    input  logic   mem_i,
    output ikind_e kind_o
);
    always_comb begin
        kind_o = classify(valid_i, sync_i, mem_i);
    end
endmodule

// File: rtl/fence_gate.sv
module fence_gate
    import fence_pkg::*;
(
    input  ikind_e kind_i,
    input  logic   cnt_zero_i,
    input  logic   cnt_full_i,
    output logic   stall_o,
    output logic   issue_o,
    output logic   retire_o
);
    always_comb begin
        stall_o  = 1'b0;
        issue_o  = 1'b0;
        retire_o = 1'b0;
        unique case (kind_i)
            KIND_SYNC: begin
                stall_o  = !cnt_zero_i;
                retire_o = cnt_zero_i;
            end
            KIND_MEM: begin
                stall_o  = cnt_full_i;
                issue_o  = !cnt_full_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fence_count.sv
module fence_count #(
    parameter int MAX_OUT = 6,
    localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             rcpt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o,
    output logic             full_o,
    output logic             err_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             err;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       dec;

    always_comb begin
        st_d     = st_q;
        dec      = rcpt_i && (st_q.cnt != '0);
        st_d.cnt = st_q.cnt + CNT_W'(inc_i) - CNT_W'(dec);
        st_d.err = rcpt_i && (st_q.cnt == '0);
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign zero_o = (st_q.cnt == '0);
    assign full_o = (st_q.cnt == CNT_W'(MAX_OUT));
    assign err_o  = st_q.err;
endmodule

// File: rtl/fence_unit.sv
module fence_unit
    import fence_pkg::*;
#(
    parameter int MAX_OUT = 6,
    localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid_i,
    input  logic             instr_sync_i,
    input  logic             instr_mem_i,
    input  logic             rcpt_i,
    output logic             stall_o,
    output logic             mem_issue_o,
    output logic             sync_retire_o,
    output logic             rcpt_err_o,
    output logic [CNT_W-1:0] pend_cnt_o
);
    ikind_e kind;
    logic   cnt_zero;
    logic   cnt_full;

    fence_classify u_cls (
        .valid_i (instr_valid_i),
        .sync_i  (instr_sync_i),
        .mem_i   (instr_mem_i),
        .kind_o  (kind)
    );

    fence_gate u_gate (
        .kind_i     (kind),
        .cnt_zero_i (cnt_zero),
        .cnt_full_i (cnt_full),
        .stall_o    (stall_o),
        .issue_o    (mem_issue_o),
        .retire_o   (sync_retire_o)
    );

    fence_count #(.MAX_OUT(MAX_OUT)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .inc_i  (mem_issue_o),
        .rcpt_i (rcpt_i),
        .cnt_o  (pend_cnt_o),
        .zero_o (cnt_zero),
        .full_o (cnt_full),
        .err_o  (rcpt_err_o)
    );
endmodule

// File: rtl/fence_unit_chk.sv
module fence_unit_chk #(
    parameter int MAX_OUT = 6,
    localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             instr_valid_i,
    input logic             instr_sync_i,
    input logic             instr_mem_i,
    input logic             rcpt_i,
    input logic             stall_o,
    input logic             mem_issue_o,
    input logic             sync_retire_o,
    input logic             rcpt_err_o,
    input logic [CNT_W-1:0] pend_cnt_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(MAX_OUT);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        pend_cnt_o <= FULL);

    assert_issue_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_issue_o && !rcpt_i) |=> pend_cnt_o == $past(pend_cnt_o) + 1'b1);

    assert_rcpt_dec_R3: assert property (@(posedge clk) disable iff (rst)
        (rcpt_i && !mem_issue_o && pend_cnt_o != '0) |=> pend_cnt_o == $past(pend_cnt_o) - 1'b1);

    assert_both_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (rcpt_i && mem_issue_o && pend_cnt_o != '0) |=> $stable(pend_cnt_o));

    assert_sync_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (instr_valid_i && instr_sync_i && pend_cnt_o != '0) |-> (stall_o && !sync_retire_o));

    assert_sync_free_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_valid_i && instr_sync_i && pend_cnt_o == '0) |-> (sync_retire_o && !stall_o));

    assert_full_block_R7: assert property (@(posedge clk) disable iff (rst)
        (instr_valid_i && instr_mem_i && !instr_sync_i && pend_cnt_o == FULL) |-> (stall_o && !mem_issue_o));

    assert_under_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (rcpt_i && pend_cnt_o == '0) |=> (rcpt_err_o && pend_cnt_o == CNT_W'($past(mem_issue_o))));

    assert_sync_no_mem_R9: assert property (@(posedge clk) disable iff (rst)
        instr_sync_i |-> !mem_issue_o);
endmodule

bind fence_unit fence_unit_chk #(.MAX_OUT(MAX_OUT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_valid_i (instr_valid_i),
    .instr_sync_i  (instr_sync_i),
    .instr_mem_i   (instr_mem_i),
    .rcpt_i        (rcpt_i),
    .stall_o       (stall_o),
    .mem_issue_o   (mem_issue_o),
    .sync_retire_o (sync_retire_o),
    .rcpt_err_o    (rcpt_err_o),
    .pend_cnt_o    (pend_cnt_o)
);

// File: tb/test_fence_unit.sv
module test_fence_unit;
    localparam int MAX_OUT = 6;
    localparam int CNT_W   = 3;
    localparam int NVEC    = 34;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic v = 1'b0, s = 1'b0, m = 1'b0, r = 1'b0;
    logic stall, iss, ret, err;
    logic [CNT_W-1:0] cnt;
    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    fence_unit #(.MAX_OUT(MAX_OUT)) i_fence_unit (
        .clk(clk), .rst(rst), .instr_valid_i(v), .instr_sync_i(s), .instr_mem_i(m),
        .rcpt_i(r), .stall_o(stall), .mem_issue_o(iss), .sync_retire_o(ret),
        .rcpt_err_o(err), .pend_cnt_o(cnt)
    );

    // {valid,sync,mem,rcpt, stall,issue,retire, cnt_after[2:0], err_after}
    localparam logic [10:0] VEC [NVEC] = '{
        11'b0000_000_000_0,  // idle
        11'b1100_001_000_0,  // R6 sync at zero
        11'b1010_010_001_0,  // R2
        11'b1010_010_010_0,  // R2 back to back
        11'b1010_010_011_0,
        11'b1100_100_011_0,  // R5
        11'b1101_100_010_0,  // R5 R3
        11'b1101_100_001_0,
        11'b1101_100_000_0,  // R5 last receipt
        11'b1100_001_000_0,  // R6 resumes
        11'b0001_000_000_1,  // R8
        11'b0000_000_000_0,  // R8 one cycle
        11'b1011_010_001_1,  // R8 issue with stray receipt
        11'b1011_010_001_0,  // R4
        11'b1110_100_001_0,  // R9
        11'b1010_010_010_0,
        11'b1010_010_011_0,
        11'b1010_010_100_0,
        11'b1010_010_101_0,
        11'b1010_010_110_0,  // reaches MAX_OUT
        11'b1010_100_110_0,  // R7
        11'b1000_000_110_0,  // R7 other instr
        11'b0100_000_110_0,  // R7 invalid sync
        11'b1011_100_101_0,  // R7 R3
        11'b1010_010_110_0,
        11'b1001_000_101_0,  // R3
        11'b0001_000_100_0,
        11'b0001_000_011_0,
        11'b1011_010_011_0,  // R4
        11'b0001_000_010_0,
        11'b1101_100_001_0,  // R5
        11'b1101_100_000_0,
        11'b1100_001_000_0,  // R6
        11'b0000_000_000_0
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] in);
        @(negedge clk);
        {v, s, m, r} = in;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset count", 8'(cnt), 8'd0);
        check("R1 reset stall/err", {6'd0, stall, err}, 8'd0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][10:7]);
            #5;
            check($sformatf("vec%0d R2/R5/R6/R7/R9 comb", i), {5'd0, stall, iss, ret}, {5'd0, VEC[i][6:4]});
            @(posedge clk);
            #1;
            check($sformatf("vec%0d R3/R4/R8/R10 count", i), {4'd0, cnt, err}, {4'd0, VEC[i][3:0]});
        end

        // R1: reset with requests outstanding and a sync waiting
        drive(4'b1010);
        @(posedge clk);
        drive(4'b1010);
        @(posedge clk);
        drive(4'b1101);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 mid-run reset count", 8'(cnt), 8'd0);
        check("R1 mid-run reset err", 8'(err), 8'd0);
        @(negedge clk);
        rst = 1'b0;
        {v, s, m, r} = 4'b1100;
        #5;
        check("R1 stall low after reset", {6'd0, stall, ret}, 8'b01);

        // R8: stray receipt right after reset gives one-cycle flag
        drive(4'b0001);
        @(posedge clk);
        #1;
        check("R8 stray after reset", {4'd0, cnt, err}, 8'b0001);
        drive(4'b0000);
        @(posedge clk);
        #1;
        check("R8 flag clears", 8'(err), 8'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule